// File: doc/BRIEF.md
# Reduced 4x4 inverse DCT

This block turns one 8x8 block of quantized transform coefficients into a 4x4 block of 8-bit pixels. It is used for downscaled image decoding, where each 8x8 frequency block maps straight to a quarter-size spatial block. The caller streams 64 coefficient/quantizer pairs in on a valid/ready port. The block then dequantizes them, runs a fixed-point column pass and a row pass, and streams 16 pixels out on a second valid/ready port.

Each pair is dequantized when it is accepted and kept in a coefficient store. The column pass visits the eight columns, one per cycle, and fills a 4x8 intermediate buffer. The row pass visits the four intermediate rows, one per cycle, and produces four pixels per row. Both passes share one transform kernel. That kernel has an even part, two odd sums and an asymmetric butterfly. The two passes differ only in how the 32-bit results are scaled back down. Frequency index 4, in both directions, never feeds the kernel.

Top module: `idct4_reduce`

## Requirements
- R1: The n-th accepted pair belongs to frequency row n/8 and column n%8. Its dequantized value is the low 16 bits, taken as signed, of the signed product of coefficient and quantizer.
- R2: Coefficients in frequency row 4 or frequency column 4 have no effect on any output pixel.
- R3: For inputs x0..x7 the kernel computes these values in 32-bit wraparound arithmetic:
  - E = x0·2^14 + (15137·x2 − 6270·x6) and F = x0·2^14 − (15137·x2 − 6270·x6).
  - P = 8697·x1 − 17799·x3 + 11893·x5 − 1730·x7.
  - Q = 20995·x1 + 7373·x3 − 4926·x5 − 4176·x7.
  - The four outputs, in order, are E+Q, F+P, F−P and E−Q.
- R4: The column pass feeds column c's dequantized values to the kernel. Output k becomes intermediate element (k, c) as bits 27..12 of (value + 2048), and that sum is formed without overflow.
- R5: The row pass feeds intermediate row r to the kernel. For each output value it takes the top 16 bits h, then computes ((h + 4) >> 3) + 128 with an arithmetic shift.
- R6: The pixel value is the row-pass result clamped to the range 0..255.
- R7: A column whose six used AC values are all zero writes 4 × DC, truncated to 16 bits, to all four intermediate rows. This is identical to what the full computation gives.
- R8: Exactly 16 pixels are emitted per block. The n-th pixel is at row n/4 and column n%4, and column k of a row is that row's kernel output k.
- R9: While a pixel is offered and not taken, outValid stays high and outPixel stays unchanged. inReady is low from the 64th accepted pair until the 16th pixel is taken.
- R10: A synchronous active-high reset leaves inReady high and outValid low. It discards any partly loaded block, so the next 64 pairs form a fresh block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Coefficient pair offered |
| inReady | output | 1 | Block accepts a pair this cycle |
| inCoef | input | 16 | Signed quantized coefficient |
| inQuant | input | 16 | Signed quantizer value |
| outValid | output | 1 | Pixel offered |
| outReady | input | 1 | Consumer takes the pixel this cycle |
| outPixel | output | 8 | Unsigned pixel value |

## Verification
DC-only blocks are swept over a range of values and quantizers. Each gives a flat block of ((d+4)>>3)+128 clamped to 0..255, which tests the zero-AC column path against the closed form and reaches both clamp limits. A single nonzero coefficient is placed at each of the 64 positions with both signs. This isolates each kernel constant and each butterfly branch, shows that index 4 does nothing, and shows whether pixels come out in the wrong order. Dense random blocks with large quantizers force wraparound in dequantization and in the 32-bit sums. Random back-pressure, a long stall and resets during loading and emission exercise the handshake and the discard rule.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  localparam int COEF_W  = 16;
  localparam int PIX_W   = 8;
  localparam int BLK     = 8;
  localparam int OUT_N   = 4;
  localparam int ACC_W   = 32;
  localparam int FRAC_W  = 13;
  localparam int EVEN_SH = FRAC_W + 1;
  localparam int P1_SH   = FRAC_W - 1;
  localparam int DC_SH   = EVEN_SH - P1_SH;
  localparam int P2_SH   = 3;
  localparam int CENTER  = 1 << (PIX_W - 1);

  localparam int NCOEF     = BLK * BLK;
  localparam int IDX_W     = $clog2(NCOEF);
  localparam int COL_W     = $clog2(BLK);
  localparam int ROW_W     = $clog2(OUT_N);
  localparam int NPIX      = OUT_N * OUT_N;
  localparam int PIX_IDX_W = $clog2(NPIX);

  // kernel constants, scaled by 2^FRAC_W
  localparam int K_E2 = 15137;
  localparam int K_E6 = 6270;
  localparam int K_P1 = 8697;
  localparam int K_P3 = 17799;
  localparam int K_P5 = 11893;
  localparam int K_P7 = 1730;
  localparam int K_Q1 = 20995;
  localparam int K_Q3 = 7373;
  localparam int K_Q5 = 4926;
  localparam int K_Q7 = 4176;

  typedef enum logic [1:0] {ST_LOAD, ST_COLS, ST_ROWS, ST_EMIT} phase_t;

  typedef struct packed {
    logic                 load;
    logic [IDX_W-1:0]     loadIdx;
    logic                 cols;
    logic [COL_W-1:0]     colSel;
    logic                 rows;
    logic [ROW_W-1:0]     rowSel;
    logic [PIX_IDX_W-1:0] outIdx;
  } strobe_t;
endpackage

// File: rtl/idct4_kernel.sv
module idct4_kernel
  import idct4_pkg::*;
#(
  parameter int XW = COEF_W,
  parameter int AW = ACC_W
) (
  input  logic signed [XW-1:0] x0,
  input  logic signed [XW-1:0] x1,
  input  logic signed [XW-1:0] x2,
  input  logic signed [XW-1:0] x3,
  input  logic signed [XW-1:0] x5,
  input  logic signed [XW-1:0] x6,
  input  logic signed [XW-1:0] x7,
  output logic signed [AW-1:0] y0,
  output logic signed [AW-1:0] y1,
  output logic signed [AW-1:0] y2,
  output logic signed [AW-1:0] y3
);
  logic signed [AW-1:0] w0, w1, w2, w3, w5, w6, w7;
  logic signed [AW-1:0] t0, t2, e10, e12, oddP, oddQ;

  assign w0 = AW'(x0);
  assign w1 = AW'(x1);
  assign w2 = AW'(x2);
  assign w3 = AW'(x3);
  assign w5 = AW'(x5);
  assign w6 = AW'(x6);
  assign w7 = AW'(x7);

  // even part
  assign t0  = w0 <<< EVEN_SH;
  assign t2  = w2 * AW'(K_E2) - w6 * AW'(K_E6);
  assign e10 = t0 + t2;
  assign e12 = t0 - t2;

  // two odd sums
  assign oddP = w1 * AW'(K_P1) - w3 * AW'(K_P3) + w5 * AW'(K_P5) - w7 * AW'(K_P7);
  assign oddQ = w1 * AW'(K_Q1) + w3 * AW'(K_Q3) - w5 * AW'(K_Q5) - w7 * AW'(K_Q7);

  // asymmetric butterfly
  assign y0 = e10 + oddQ;
  assign y3 = e10 - oddQ;
  assign y1 = e12 + oddP;
  assign y2 = e12 - oddP;
endmodule

// File: rtl/idct4_ctrl.sv
module idct4_ctrl
  import idct4_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t stb
);
  phase_t           phase;
  logic [IDX_W-1:0] cnt;
  logic             step;
  logic             last;
  phase_t           nextPhase;

  always_comb begin
    step      = 1'b1;
    last      = 1'b0;
    nextPhase = phase;
    unique case (phase)
      ST_LOAD: begin
        step      = inValid;
        last      = (cnt == IDX_W'(NCOEF - 1));
        nextPhase = ST_COLS;
      end
      ST_COLS: begin
        last      = (cnt == IDX_W'(BLK - 1));
        nextPhase = ST_ROWS;
      end
      ST_ROWS: begin
        last      = (cnt == IDX_W'(OUT_N - 1));
        nextPhase = ST_EMIT;
      end
      ST_EMIT: begin
        step      = outReady;
        last      = (cnt == IDX_W'(NPIX - 1));
        nextPhase = ST_LOAD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_LOAD;
      cnt   <= '0;
    end else if (step) begin
      if (last) begin
        phase <= nextPhase;
        cnt   <= '0;
      end else begin
        cnt <= cnt + IDX_W'(1);
      end
    end
  end

  assign inReady  = (phase == ST_LOAD);
  assign outValid = (phase == ST_EMIT);

  always_comb begin
    stb.load    = inReady && inValid;
    stb.loadIdx = cnt;
    stb.cols    = (phase == ST_COLS);
    stb.colSel  = cnt[COL_W-1:0];
    stb.rows    = (phase == ST_ROWS);
    stb.rowSel  = cnt[ROW_W-1:0];
    stb.outIdx  = cnt[PIX_IDX_W-1:0];
  end
endmodule

// File: rtl/idct4_dp.sv
module idct4_dp
  import idct4_pkg::*;
#(
  parameter int CW = COEF_W,
  parameter int PW = PIX_W,
  parameter int AW = ACC_W
) (
  input  logic                 clk,
  input  strobe_t              stb,
  input  logic signed [CW-1:0] inCoef,
  input  logic signed [CW-1:0] inQuant,
  output logic [PW-1:0]        outPixel
);
  localparam int PMAX = (1 << PW) - 1;

  logic signed [CW-1:0] coefMem [NCOEF];
  logic signed [CW-1:0] midBuf  [OUT_N][BLK];
  logic [PW-1:0]        pixBuf  [NPIX];

  // dequantize on the way in, keep the low half of the product
  logic signed [2*CW-1:0] prod;
  logic                   unusedProd;
  assign prod       = inCoef * inQuant;
  assign unusedProd = ^prod[2*CW-1:CW];

  always_ff @(posedge clk) begin
    if (stb.load) coefMem[stb.loadIdx] <= prod[CW-1:0];
  end

  // kernel operand select: column of the store, or row of the buffer
  function automatic logic signed [CW-1:0] pick(input int k);
    logic [COL_W-1:0] kk;
    kk = k[COL_W-1:0];
    if (stb.rows) return midBuf[stb.rowSel][kk];
    return coefMem[{kk, stb.colSel}];
  endfunction

  logic signed [CW-1:0] x0, x1, x2, x3, x5, x6, x7;
  assign x0 = pick(0);
  assign x1 = pick(1);
  assign x2 = pick(2);
  assign x3 = pick(3);
  assign x5 = pick(5);
  assign x6 = pick(6);
  assign x7 = pick(7);

  logic signed [AW-1:0] ys [OUT_N];

  idct4_kernel #(.XW(CW), .AW(AW)) u_kernel (
    .x0(x0), .x1(x1), .x2(x2), .x3(x3), .x5(x5), .x6(x6), .x7(x7),
    .y0(ys[0]), .y1(ys[1]), .y2(ys[2]), .y3(ys[3])
  );

  logic acZero;
  assign acZero = ((x1 | x2 | x3 | x5 | x6 | x7) == '0);

  logic [CW-1:0] colVal [OUT_N];
  logic [PW-1:0] pixVal [OUT_N];

  for (genvar r = 0; r < OUT_N; r++) begin : g_lane
    // column pass descale: rounding shift, narrow
    logic [AW:0] rnd;
    logic        unusedRnd;
    assign rnd       = {ys[r][AW-1], ys[r]} + (AW+1)'(1 << (P1_SH - 1));
    assign unusedRnd = ^{rnd[P1_SH-1:0], rnd[AW:P1_SH+CW]};
    assign colVal[r] = acZero ? CW'(x0 <<< DC_SH) : rnd[P1_SH +: CW];

    // row pass descale: high half, rounding shift, recenter, clamp
    logic signed [CW-1:0] hi;
    logic signed [CW:0]   rsh;
    logic signed [CW:0]   ctr;
    logic                 unusedLow;
    assign hi        = ys[r][AW-1 -: CW];
    assign unusedLow = ^ys[r][AW-CW-1:0];
    assign rsh       = ($signed({hi[CW-1], hi}) + (CW+1)'(1 << (P2_SH - 1))) >>> P2_SH;
    assign ctr       = rsh + (CW+1)'(CENTER);
    assign pixVal[r] = (ctr < 0) ? '0 :
                       (ctr > (CW+1)'(PMAX)) ? PW'(PMAX) : ctr[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (stb.cols) begin
      for (int r = 0; r < OUT_N; r++) midBuf[r][stb.colSel] <= colVal[r];
    end
    if (stb.rows) begin
      for (int c = 0; c < OUT_N; c++) pixBuf[{stb.rowSel, c[ROW_W-1:0]}] <= pixVal[c];
    end
  end

  assign outPixel = pixBuf[stb.outIdx];
endmodule

// File: rtl/idct4_reduce.sv
module idct4_reduce
  import idct4_pkg::*;
#(
  parameter int CW = COEF_W,
  parameter int PW = PIX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic signed [CW-1:0] inCoef,
  input  logic signed [CW-1:0] inQuant,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [PW-1:0]        outPixel
);
  strobe_t stb;

  idct4_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .stb(stb)
  );

  idct4_dp #(.CW(CW), .PW(PW), .AW(ACC_W)) u_dp (
    .clk(clk), .stb(stb), .inCoef(inCoef), .inQuant(inQuant), .outPixel(outPixel)
  );
endmodule

// File: rtl/idct4_reduce_chk.sv
module idct4_reduce_chk
  import idct4_pkg::*;
#(
  parameter int PW = PIX_W
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic          inReady,
  input logic          outValid,
  input logic          outReady,
  input logic [PW-1:0] outPixel
);
  logic [PIX_IDX_W-1:0] outCnt;
  logic                 pastRst;

  always_ff @(posedge clk) begin
    pastRst <= rst;
    if (rst) outCnt <= '0;
    else if (outValid && outReady) outCnt <= outCnt + PIX_IDX_W'(1);
  end

  // R9: offered pixel is held until taken
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outPixel)));

  // R9: never loading and emitting at once
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));

  // R8: a new block is only accepted once all 16 pixels of the last are out
  a_r8_sixteen: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> (outCnt == '0));

  // R10: state right after a reset edge
  always @(negedge clk) begin
    if (pastRst === 1'b1) begin
      a_r10_reset_state: assert (inReady && !outValid);
    end
  end
endmodule

bind idct4_reduce idct4_reduce_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
);

// File: tb/idct4_reduce_tb.sv
`timescale 1ns/1ps
module idct4_reduce_tb;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic              inReady;
  logic signed [15:0] inCoef = '0;
  logic signed [15:0] inQuant = '0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [7:0]        outPixel;

  always #2 clk = ~clk;

  idct4_reduce u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inCoef(inCoef), .inQuant(inQuant), .outValid(outValid),
    .outReady(outReady), .outPixel(outPixel)
  );

  int vectors = 0;
  int fails   = 0;
  shortint cf [64];
  shortint qt [64];
  int expPix [16];
  int keepPix [16];

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // ---------- reference arithmetic ----------
  function automatic void kern(input int a0, a1, a2, a3, a5, a6, a7,
                               output int y0, y1, y2, y3);
    int t0, t2, e10, e12, p, q;
    t0  = a0 * 16384;
    t2  = 15137 * a2 - 6270 * a6;
    e10 = t0 + t2;
    e12 = t0 - t2;
    p   = 8697 * a1 - 17799 * a3 + 11893 * a5 - 1730 * a7;
    q   = 20995 * a1 + 7373 * a3 - 4926 * a5 - 4176 * a7;
    y0 = e10 + q; y3 = e10 - q;
    y1 = e12 + p; y2 = e12 - p;
  endfunction

  function automatic shortint colDescale(input int y);
    longint v;
    v = longint'(y) + 64'sd2048;
    return shortint'(v >>> 12);
  endfunction

  function automatic int rowDescale(input int y);
    shortint h;
    int v;
    h = shortint'(y >>> 16);
    v = ((int'(h) + 4) >>> 3) + 128;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic void computeExpected();
    shortint d [64];
    shortint w [4][8];
    int y [4];
    for (int i = 0; i < 64; i++) d[i] = shortint'(int'(cf[i]) * int'(qt[i]));
    for (int c = 0; c < 8; c++) begin
      kern(d[c], d[8+c], d[16+c], d[24+c], d[40+c], d[48+c], d[56+c],
           y[0], y[1], y[2], y[3]);
      for (int r = 0; r < 4; r++) w[r][c] = colDescale(y[r]);
    end
    for (int r = 0; r < 4; r++) begin
      kern(w[r][0], w[r][1], w[r][2], w[r][3], w[r][5], w[r][6], w[r][7],
           y[0], y[1], y[2], y[3]);
      for (int k = 0; k < 4; k++) expPix[r*4+k] = rowDescale(y[k]);
    end
  endfunction

  function automatic int srnd(input int mag);
    return int'($urandom % (2 * mag + 1)) - mag;
  endfunction

  // ---------- stimulus ----------
  task automatic clearBlock(input shortint q);
    for (int i = 0; i < 64; i++) begin cf[i] = 0; qt[i] = q; end
  endtask

  task automatic loadPairs(input int upto);
    for (int i = 0; i < upto; i++) begin
      if ($urandom % 8 == 0) begin inValid = 1'b0; @(negedge clk); end
      inValid = 1'b1; inCoef = cf[i]; inQuant = qt[i];
      while (!inReady) @(negedge clk);
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic collect(input string req, input int count);
    int got = 0;
    while (got < count) begin
      outReady = ($urandom % 4) != 0;
      if (outValid && outReady) begin
        chk(req, int'(outPixel), expPix[got]);
        keepPix[got] = int'(outPixel);
        got++;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
  endtask

  task automatic runBlock(input string req);
    computeExpected();
    loadPairs(64);
    collect(req, 16);
  endtask

  task automatic pulseReset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 inReady after reset", int'(inReady), 1);
    chk("R10 outValid after reset", int'(outValid), 0);

    // R7 / R6: DC-only blocks, flat output ((d+4)>>3)+128 clamped
    for (int dv = -1200; dv <= 1200; dv += 150) begin
      clearBlock(1);
      cf[0] = shortint'(dv);
      runBlock("R7");
    end
    clearBlock(8); cf[0] = 500;  computeExpected();
    chk("R6 model high clamp", expPix[5], 255);
    runBlock("R6");
    clearBlock(8); cf[0] = -500;
    runBlock("R6");
    for (int k = 0; k < 16; k++) chk("R6 low clamp", keepPix[k], 0);

    // R1: dequantization wraps to 16 bits
    clearBlock(1); cf[0] = 300; qt[0] = 300; runBlock("R1");
    clearBlock(1); cf[0] = 181; qt[0] = -181; cf[9] = 250; qt[9] = 263; runBlock("R1");

    // R3 / R2 / R8: single impulse at every position, both signs
    for (int pos = 0; pos < 64; pos++) begin
      for (int s = 0; s < 2; s++) begin
        clearBlock(5);
        cf[pos] = (s == 0) ? 16'sd37 : -16'sd52;
        if (pos / 8 == 4 || pos % 8 == 4) runBlock("R2");
        else runBlock("R3");
      end
    end

    // R2: index-4 entries change nothing
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 64; i++) begin
        cf[i] = (i / 8 == 4 || i % 8 == 4) ? 16'sd0 : shortint'(srnd(40));
        qt[i] = shortint'(1 + $urandom % 16);
      end
      runBlock("R3");
      for (int i = 0; i < 64; i++)
        if (i / 8 == 4 || i % 8 == 4) cf[i] = shortint'(srnd(3000));
      loadPairs(64);
      collect("R2", 16);
    end

    // R4 / R5 / R8: dense and sparse random blocks, some with large quantizers
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < 64; i++) begin
        cf[i] = (t % 2 == 0 || $urandom % 4 == 0) ? shortint'(srnd(60)) : 16'sd0;
        qt[i] = shortint'(1 + $urandom % 12);
      end
      runBlock((t % 2 == 0) ? "R4" : "R5");
    end
    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < 64; i++) begin
        cf[i] = shortint'(srnd(2047));
        qt[i] = shortint'(1 + $urandom % 255);
      end
      runBlock("R1");
    end

    // R9: long stall holds pixel and blocks input
    for (int i = 0; i < 64; i++) begin cf[i] = shortint'(srnd(30)); qt[i] = 3; end
    computeExpected();
    loadPairs(64);
    while (!outValid) @(negedge clk);
    begin
      int held;
      held = int'(outPixel);
      repeat (12) @(negedge clk);
      chk("R9 pixel held", int'(outPixel), held);
      chk("R9 valid held", int'(outValid), 1);
      chk("R9 input blocked", int'(inReady), 0);
    end
    collect("R8", 16);

    // R10: reset during loading discards the partial block
    for (int i = 0; i < 64; i++) begin cf[i] = shortint'(srnd(500)); qt[i] = 7; end
    loadPairs(30);
    pulseReset();
    chk("R10 idle after mid-load reset", int'(outValid), 0);
    for (int i = 0; i < 64; i++) begin cf[i] = shortint'(srnd(50)); qt[i] = 2; end
    runBlock("R10");

    // R10: reset during emission
    computeExpected();
    loadPairs(64);
    collect("R8", 5);
    pulseReset();
    chk("R10 outValid after mid-emit reset", int'(outValid), 0);
    chk("R10 inReady after mid-emit reset", int'(inReady), 1);
    for (int i = 0; i < 64; i++) begin cf[i] = shortint'(srnd(80)); qt[i] = 4; end
    runBlock("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule